// File: doc/BRIEF.md
# USB Endpoint IN-Transaction Responder

This block keeps the transmit control state for one control endpoint (endpoint 0) and three interrupt endpoints of a low-speed USB function. For every IN token it chooses the handshake or data packet to send. The possible answers are NAK, STALL, or a DATA0/DATA1 packet with a byte count. The serial engine supplies decoded token events and a strobe that marks a received host ACK. Firmware programs each endpoint through a byte-wide register port.

Endpoint 0 has its own control byte at address 0. Endpoints 1 to 3 share the control byte at address 1, and the endpoint it reaches is chosen by the select register at address 2. Firmware must write the select register before the shared control byte.

The output-enable bit clears itself in two cases: when the host acknowledges a data packet, and, on endpoint 0 only, when a SETUP or OUT token arrives for that endpoint. If firmware writes a control byte in the same cycle as one of these clears, the firmware value is kept.

Top module: `usb_in_responder`

## Requirements
- R1: After reset, every control byte reads 00h, the select register reads 0, and `resp_valid` is 0.
- R2: An IN token (`tok_type`=0) to an endpoint whose control byte has bit 6 (stall) at 0 and bit 5 (output enable) at 0 gives a response one cycle later with `resp_code`=0 (NAK) and `resp_len`=0.
- R3: An IN token to an endpoint whose stall bit 6 is 1 gives `resp_code`=1 (STALL) and `resp_len`=0. This holds whatever the output-enable bit is.
- R4: An IN token to an endpoint that is not stalled and has output enable set gives DATA0 (`resp_code`=2) when bit 4 (sequence) is 0, and DATA1 (`resp_code`=3) when bit 4 is 1. `resp_len` equals the count in bits 3:0.
- R5: A count in bits 3:0 above 8 is sent as a length of 8.
- R6: An `ack_in` pulse after a data response, with no token in between, clears bit 5 of the endpoint that sent the data. If no ACK arrives, bit 5 stays set and a repeated IN sends the same packet again. An `ack_in` with no data response pending changes nothing.
- R7: An OUT (`tok_type`=1) or SETUP (`tok_type`=2) token addressed to endpoint 0 clears bit 5 of endpoint 0. The same token addressed to endpoints 1 to 3 leaves their control bytes unchanged.
- R8: Address 2 holds the endpoint select in bits 1:0. Address 1 writes and reads the control byte of the selected endpoint (1 to 3). While the select is 0, writes to address 1 are ignored and reads of address 1 return 0. Bit 7 of every control byte reads 0.
- R9: A firmware write to a control byte in the same cycle as a hardware clear of that byte stores the written value.
- R10: Any token received after a data response cancels the pending ACK. A later `ack_in` then leaves the output-enable bit set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cpu_wr | input | 1 | Register write strobe |
| cpu_addr | input | 2 | Register address: 0 = endpoint 0 control, 1 = shared control, 2 = select |
| cpu_wdata | input | 8 | Register write data |
| cpu_rdata | output | 8 | Register read data for `cpu_addr` (combinational) |
| tok_valid | input | 1 | Decoded token event |
| tok_type | input | 2 | Token kind: 0 = IN, 1 = OUT, 2 = SETUP, 3 = ignored |
| tok_ep | input | 2 | Endpoint number of the token |
| ack_in | input | 1 | Host ACK received |
| resp_valid | output | 1 | Response to an IN token, one cycle after the token |
| resp_code | output | 2 | 0 = NAK, 1 = STALL, 2 = DATA0, 3 = DATA1 |
| resp_len | output | 4 | Data byte count (0 for a handshake) |

## Verification
In one cycle a hardware clear of the output-enable bit (an ACK for a pending packet, or an OUT/SETUP to endpoint 0) can meet a firmware write to the same control byte. Likewise an ACK can arrive in the same cycle as, or just after, a token that should cancel it. The bench provokes both cases by driving `ack_in` together with a write to the selected endpoint, and by putting an OUT token between a data response and its ACK. It then reads the control byte back through the register port. A behavioural reference model, updated on every clock, predicts the response and the read data, and both are compared every cycle.

// File: rtl/usb_in_responder.sv
module usb_in_responder #(
  parameter int EP_W    = 2,
  parameter int MAX_LEN = 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            cpu_wr,
  input  logic [1:0]      cpu_addr,
  input  logic [7:0]      cpu_wdata,
  output logic [7:0]      cpu_rdata,
  input  logic            tok_valid,
  input  logic [1:0]      tok_type,
  input  logic [EP_W-1:0] tok_ep,
  input  logic            ack_in,
  output logic            resp_valid,
  output logic [1:0]      resp_code,
  output logic [3:0]      resp_len
);
  localparam int N_EP = 1 << EP_W;
  localparam logic [3:0] MAX_L = 4'(MAX_LEN);
  localparam logic [1:0] T_IN = 2'd0, T_OUT = 2'd1, T_SETUP = 2'd2;
  localparam logic [1:0] C_NAK = 2'd0, C_STALL = 2'd1;
  localparam int B_STL = 6, B_OE = 5, B_SEQ = 4;

  logic [6:0]      ctl [N_EP];
  logic [EP_W-1:0] sel;
  logic            pend_v;
  logic [EP_W-1:0] pend_ep;
  logic [N_EP-1:0] wr_v, clr_v;
  logic [6:0]      cur;
  logic            in_hit, send_data, ep0_rx;

  assign cur       = ctl[tok_ep];
  assign in_hit    = tok_valid && tok_type == T_IN;
  assign send_data = in_hit && !cur[B_STL] && cur[B_OE];
  assign ep0_rx    = tok_valid && (tok_type == T_OUT || tok_type == T_SETUP) && tok_ep == '0;

  always_comb begin
    for (int i = 0; i < N_EP; i++) begin
      clr_v[i] = (ack_in && pend_v && pend_ep == EP_W'(i)) || (i == 0 && ep0_rx);
      if (i == 0) wr_v[i] = cpu_wr && cpu_addr == 2'd0;
      else        wr_v[i] = cpu_wr && cpu_addr == 2'd1 && sel == EP_W'(i);
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < N_EP; i++) ctl[i] <= '0;
    end else begin
      for (int i = 0; i < N_EP; i++) begin
        if (wr_v[i])       ctl[i] <= cpu_wdata[6:0];
        else if (clr_v[i]) ctl[i][B_OE] <= 1'b0;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sel     <= '0;
      pend_v  <= 1'b0;
      pend_ep <= '0;
    end else begin
      if (cpu_wr && cpu_addr == 2'd2) sel <= cpu_wdata[EP_W-1:0];
      if (tok_valid) begin
        pend_v  <= send_data;
        pend_ep <= tok_ep;
      end else if (ack_in) begin
        pend_v  <= 1'b0;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      resp_valid <= 1'b0;
      resp_code  <= C_NAK;
      resp_len   <= '0;
    end else begin
      resp_valid <= in_hit;
      if (in_hit) begin
        if (cur[B_STL])     begin resp_code <= C_STALL;          resp_len <= '0; end
        else if (cur[B_OE]) begin
          resp_code <= {1'b1, cur[B_SEQ]};
          resp_len  <= (cur[3:0] > MAX_L) ? MAX_L : cur[3:0];
        end
        else                begin resp_code <= C_NAK;            resp_len <= '0; end
      end
    end
  end

  always_comb begin
    case (cpu_addr)
      2'd0:    cpu_rdata = {1'b0, ctl[0]};
      2'd1:    cpu_rdata = (sel != '0) ? {1'b0, ctl[sel]} : 8'h00;
      2'd2:    cpu_rdata = 8'(sel);
      default: cpu_rdata = 8'h00;
    endcase
  end

  a_r1_resp_only_after_in: assert property (@(posedge clk) disable iff (!rst_n)
    resp_valid |-> $past(tok_valid && tok_type == T_IN));

  a_r2_handshake_no_len: assert property (@(posedge clk) disable iff (!rst_n)
    (resp_valid && !resp_code[1]) |-> resp_len == 4'd0);

  a_r3_stall_wins: assert property (@(posedge clk) disable iff (!rst_n)
    (in_hit && cur[B_STL]) |=> (resp_valid && resp_code == C_STALL));

  a_r5_len_clamped: assert property (@(posedge clk) disable iff (!rst_n)
    resp_valid |-> resp_len <= MAX_L);

  a_r6_ack_clears_oe: assert property (@(posedge clk) disable iff (!rst_n)
    (ack_in && pend_v && !wr_v[pend_ep]) |=> !ctl[$past(pend_ep)][B_OE]);

  a_r7_ep0_rx_clears_oe: assert property (@(posedge clk) disable iff (!rst_n)
    (ep0_rx && !wr_v[0]) |=> !ctl[0][B_OE]);

  a_r9_write_wins_ep0: assert property (@(posedge clk) disable iff (!rst_n)
    wr_v[0] |=> ctl[0] == $past(cpu_wdata[6:0]));
endmodule

// File: tb/test_usb_in_responder.sv
module test_usb_in_responder;
  logic       clk = 0, rst_n = 0;
  logic       cpu_wr = 0, tok_valid = 0, ack_in = 0;
  logic [1:0] cpu_addr = 0, tok_type = 0, tok_ep = 0;
  logic [7:0] cpu_wdata = 0, cpu_rdata;
  logic       resp_valid;
  logic [1:0] resp_code;
  logic [3:0] resp_len;
  int checks = 0, errors = 0;

  always #4 clk = ~clk;

  usb_in_responder i_usb_in_responder (
    .clk(clk), .rst_n(rst_n), .cpu_wr(cpu_wr), .cpu_addr(cpu_addr),
    .cpu_wdata(cpu_wdata), .cpu_rdata(cpu_rdata), .tok_valid(tok_valid),
    .tok_type(tok_type), .tok_ep(tok_ep), .ack_in(ack_in),
    .resp_valid(resp_valid), .resp_code(resp_code), .resp_len(resp_len));

  task automatic chk(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // reference model
  int m_ctl[4];
  int m_sel, m_pe;
  bit m_pv, e_rv;
  int e_code, e_len;

  always @(posedge clk) begin
    if (!rst_n) begin
      foreach (m_ctl[i]) m_ctl[i] = 0;
      m_sel = 0; m_pv = 0; m_pe = 0; e_rv = 0; e_code = 0; e_len = 0;
    end else begin
      int c;
      bit data_now;
      bit [3:0] clr;
      c = m_ctl[tok_ep];
      data_now = 0;
      e_rv = tok_valid && tok_type == 0;
      if (e_rv) begin
        if (c & 'h40)      begin e_code = 1; e_len = 0; end
        else if (c & 'h20) begin
          e_code = (c & 'h10) ? 3 : 2;
          e_len = ((c & 15) > 8) ? 8 : (c & 15);
          data_now = 1;
        end else           begin e_code = 0; e_len = 0; end
      end
      clr = 0;
      if (ack_in && m_pv) clr[m_pe] = 1;
      if (tok_valid && (tok_type == 1 || tok_type == 2) && tok_ep == 0) clr[0] = 1;
      foreach (m_ctl[i]) if (clr[i]) m_ctl[i] = m_ctl[i] & 'h5F;
      if (cpu_wr && cpu_addr == 0) m_ctl[0] = cpu_wdata & 'h7F;
      if (cpu_wr && cpu_addr == 1 && m_sel != 0) m_ctl[m_sel] = cpu_wdata & 'h7F;
      if (tok_valid) begin m_pv = data_now; m_pe = tok_ep; end
      else if (ack_in) m_pv = 0;
      if (cpu_wr && cpu_addr == 2) m_sel = cpu_wdata & 3;
    end
  end

  always @(posedge clk) begin
    #3;
    if (rst_n) begin
      int er;
      case (cpu_addr)
        0: er = m_ctl[0];
        1: er = m_sel ? m_ctl[m_sel] : 0;
        2: er = m_sel;
        default: er = 0;
      endcase
      chk("R8 model rdata", cpu_rdata, er);
      chk("R1 model resp_valid", resp_valid, e_rv);
      if (e_rv) begin
        chk(e_code == 1 ? "R3 model code" : e_code == 0 ? "R2 model code" : "R4 model code",
            resp_code, e_code);
        chk("R5 model len", resp_len, e_len);
      end
    end
  end

  task automatic wr(int a, int d);
    @(negedge clk); cpu_wr = 1; cpu_addr = 2'(a); cpu_wdata = 8'(d);
    @(negedge clk); cpu_wr = 0;
  endtask

  task automatic rd(int a, output int d);
    @(negedge clk); cpu_addr = 2'(a); #1 d = cpu_rdata;
  endtask

  task automatic tok(int t, int ep, output int code, output int len);
    @(negedge clk); tok_valid = 1; tok_type = 2'(t); tok_ep = 2'(ep);
    @(negedge clk); tok_valid = 0; code = resp_valid ? resp_code : -1; len = resp_len;
  endtask

  task automatic ack();
    @(negedge clk); ack_in = 1;
    @(negedge clk); ack_in = 0;
  endtask

  initial begin
    #1600000;
    errors++; checks++;
    $display("FAIL watchdog expired actual=1 expected=0");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    int d, c, l;
    repeat (3) @(negedge clk);
    rst_n = 1;
    rd(0, d); chk("R1 ep0 reset", d, 0);
    rd(2, d); chk("R1 select reset", d, 0);
    chk("R1 resp_valid reset", resp_valid, 0);

    wr(0, 'h35);
    tok(0, 0, c, l); chk("R4 DATA1 code", c, 3); chk("R4 length", l, 5);
    tok(0, 0, c, l); chk("R6 retry without ack", c, 3);
    ack();
    rd(0, d); chk("R6 ack clears oe", d, 'h15);
    tok(0, 0, c, l); chk("R2 NAK", c, 0); chk("R2 NAK len", l, 0);
    wr(0, 'h60);
    tok(0, 0, c, l); chk("R3 STALL over oe", c, 1);
    wr(0, 'h2C);
    tok(0, 0, c, l); chk("R5 DATA0 code", c, 2); chk("R5 clamp", l, 8);
    ack();
    wr(0, 'h21); ack();
    rd(0, d); chk("R6 stray ack ignored", d, 'h21);

    wr(0, 'h23);
    tok(1, 0, c, l); rd(0, d); chk("R7 OUT ep0 clears oe", d, 'h03);
    wr(0, 'h23);
    tok(2, 0, c, l); rd(0, d); chk("R7 SETUP ep0 clears oe", d, 'h03);
    wr(2, 1); wr(1, 'h22);
    tok(1, 1, c, l); rd(1, d); chk("R7 OUT ep1 no effect", d, 'h22);

    wr(2, 2); wr(1, 'h31);
    rd(1, d); chk("R8 ep2 via shared", d, 'h31);
    wr(2, 1); rd(1, d); chk("R8 ep1 unchanged", d, 'h22);
    wr(2, 0); wr(1, 'hFF);
    rd(1, d); chk("R8 sel0 reads zero", d, 0);
    wr(2, 3); rd(1, d); chk("R8 sel0 write ignored", d, 0);

    wr(2, 1);
    tok(0, 1, c, l); chk("R4 ep1 DATA0", c, 2);
    @(negedge clk); ack_in = 1; cpu_wr = 1; cpu_addr = 1; cpu_wdata = 'h27;
    @(negedge clk); ack_in = 0; cpu_wr = 0;
    rd(1, d); chk("R9 write beats ack clear", d, 'h27);

    tok(0, 1, c, l); chk("R4 ep1 len", l, 7);
    tok(1, 3, c, l);
    ack();
    rd(1, d); chk("R10 token cancels ack", d, 'h27);

    repeat (3) @(negedge clk);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule